// File: doc/BRIEF.md
# NAND Hamming Parity Accumulator

This block sits on the byte path between a host register bus and a NAND flash device. Every byte that crosses the flash data port, whether the host writes it toward the flash or reads it back, is folded into a running Hamming parity for the current 256-byte step. The block keeps three kinds of state: 16 line-parity bits built from the parity of each byte and the index of that byte within the step, 6 column-parity bits built from the bit positions inside the bytes, and an 8-bit byte counter.

The host clears the accumulators by writing to a clear register and then moves a step of data through the data port. It then reads the parity registers and the counter. The registers hold the true, non-inverted parity, and the host builds the stored code from them. The counter wraps to zero after exactly 256 bytes, so a nonzero value at read-out shows that the step was not complete.

Top module: `nand_ecc_accum`

## Requirements
- R1: After reset the line parity, the column parity and the byte counter are all zero.
- R2: Each access to the data port at offset 0x14, read or write, advances the byte counter by one. No other access changes the counter, except a clear.
- R3: The byte counter wraps from 255 to 0, so after a full 256-byte step it reads zero.
- R4: Column parity bit 2j+1 is the XOR, over all bytes of the step, of the data bits whose position has bit j set. Bit 2j is the same XOR over the positions with bit j clear, for j = 0..2.
- R5: Line parity bit 2k+1 is the XOR of the parity of every byte whose step index has bit k set. Bit 2k is the same XOR over the bytes whose index has bit k clear, for k = 0..7.
- R6: Any write to offset 0x10 zeroes both parity accumulators and the counter on the next clock edge, whatever the data.
- R7: Reads return line parity bits 7..0 at 0x00, line parity bits 15..8 at 0x04, column parity in bits 5..0 of 0x08 with bits 7..6 zero, and the counter at 0x0C. All parity values are stored raw, not inverted.
- R8: Writes to 0x00, 0x04, 0x08 and 0x0C have no effect. Reads of 0x10 and of any unmapped offset return zero.
- R9: A data-port write drives wdata_i onto flash_dq_o and pulses flash_we_o for the access cycle. A data-port read pulses flash_re_o and returns flash_dq_i on rdata_o. The two strobes are never active together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access valid this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Byte offset of the register |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational from the registers |
| flash_dq_i | input | 8 | Byte returned by the flash |
| flash_dq_o | output | 8 | Byte driven toward the flash |
| flash_we_o | output | 1 | Flash write strobe |
| flash_re_o | output | 1 | Flash read strobe |

## Verification
The bench checks the counter across the 255-to-0 wrap. A design that saturated the counter, or failed to wrap it, would show a nonzero count after a full random step. It also checks partial steps driven through flash reads, which a design that counted only writes would miss, and a clear issued partway through a step. If the clear left the index or the parity dirty, the parity of the bytes that follow would differ from the model. Hand-computed vectors catch parity pairs that are swapped or inverted, writes to read-only offsets that leak in, and nonzero upper bits in the column register.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFS_LP_LO = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_LP_HI = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_CP    = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_CNT   = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_CLR   = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_DATA  = 8'h14;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_LP_LO,
    SEL_LP_HI,
    SEL_CP,
    SEL_CNT,
    SEL_CLR,
    SEL_DATA
  } reg_sel_e;
endpackage

// File: rtl/ecc_byte_parity.sv
module ecc_byte_parity #(
  parameter int DATA_W = 8,
  localparam int POS_W = $clog2(DATA_W),
  localparam int CP_W  = 2 * POS_W
) (
  input  logic [DATA_W-1:0] byte_i,
  output logic [CP_W-1:0]   cp_o,
  output logic              rp_o
);
  always_comb begin
    cp_o = '0;
    for (int j = 0; j < POS_W; j++) begin
      for (int b = 0; b < DATA_W; b++) begin
        if (((b >> j) & 1) == 1) cp_o[2*j+1] = cp_o[2*j+1] ^ byte_i[b];
        else                     cp_o[2*j]   = cp_o[2*j]   ^ byte_i[b];
      end
    end
  end

  assign rp_o = ^byte_i;
endmodule

// File: rtl/ecc_step_acc.sv
module ecc_step_acc #(
  parameter int CNT_W = 8,
  parameter int CP_W  = 6,
  localparam int LP_W = 2 * CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             step_i,
  input  logic             rp_i,
  input  logic [CP_W-1:0]  cp_i,
  output logic [LP_W-1:0]  lp_o,
  output logic [CP_W-1:0]  cp_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [LP_W-1:0]  lp_q, lp_mask;
  logic [CP_W-1:0]  cp_q;

  // each index bit steers row parity into one of its pair
  for (genvar k = 0; k < CNT_W; k++) begin : g_mask
    assign lp_mask[2*k]   = ~cnt_q[k];
    assign lp_mask[2*k+1] =  cnt_q[k];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      lp_q  <= '0;
      cp_q  <= '0;
    end else if (clear_i) begin
      cnt_q <= '0;
      lp_q  <= '0;
      cp_q  <= '0;
    end else if (step_i) begin
      cnt_q <= cnt_q + 1'b1;
      cp_q  <= cp_q ^ cp_i;
      if (rp_i) lp_q <= lp_q ^ lp_mask;
    end
  end

  assign lp_o  = lp_q;
  assign cp_o  = cp_q;
  assign cnt_o = cnt_q;

  p_cnt_inc_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !clear_i) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));

  p_cnt_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !clear_i) |=> $stable(cnt_q));

  p_cnt_wrap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !clear_i && (&cnt_q)) |=> (cnt_q == '0));
endmodule

// File: rtl/ecc_reg_if.sv
module ecc_reg_if
  import nand_ecc_pkg::*;
#(
  parameter int LP_W  = 16,
  parameter int CP_W  = 6,
  parameter int CNT_W = 8
) (
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] flash_dq_i,
  input  logic [LP_W-1:0]   lp_i,
  input  logic [CP_W-1:0]   cp_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [DATA_W-1:0] byte_o,
  output logic              clear_o,
  output logic              step_o,
  output logic              flash_we_o,
  output logic              flash_re_o
);
  reg_sel_e sel;

  always_comb begin
    unique case (addr_i)
      OFS_LP_LO: sel = SEL_LP_LO;
      OFS_LP_HI: sel = SEL_LP_HI;
      OFS_CP:    sel = SEL_CP;
      OFS_CNT:   sel = SEL_CNT;
      OFS_CLR:   sel = SEL_CLR;
      OFS_DATA:  sel = SEL_DATA;
      default:   sel = SEL_NONE;
    endcase
  end

  assign clear_o    = req_i & we_i & (sel == SEL_CLR);
  assign flash_we_o = req_i & we_i & (sel == SEL_DATA);
  assign flash_re_o = req_i & ~we_i & (sel == SEL_DATA);
  assign step_o     = flash_we_o | flash_re_o;
  assign byte_o     = we_i ? wdata_i : flash_dq_i;

  always_comb begin
    rdata_o = '0;
    case (sel)
      SEL_LP_LO: rdata_o = lp_i[7:0];
      SEL_LP_HI: rdata_o = lp_i[15:8];
      SEL_CP:    rdata_o[CP_W-1:0] = cp_i;
      SEL_CNT:   rdata_o[CNT_W-1:0] = cnt_i;
      SEL_DATA:  rdata_o = flash_dq_i;
      default:   rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/nand_ecc_accum.sv
module nand_ecc_accum
  import nand_ecc_pkg::*;
#(
  parameter int CNT_W = 8,
  localparam int LP_W = 2 * CNT_W,
  localparam int CP_W = 2 * $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [DATA_W-1:0] flash_dq_i,
  output logic [DATA_W-1:0] flash_dq_o,
  output logic              flash_we_o,
  output logic              flash_re_o
);
  logic [DATA_W-1:0] byte_w;
  logic              clear_w, step_w, rp_w;
  logic [CP_W-1:0]   cp_byte_w, cp_acc_w;
  logic [LP_W-1:0]   lp_acc_w;
  logic [CNT_W-1:0]  cnt_w;

  ecc_reg_if #(.LP_W(LP_W), .CP_W(CP_W), .CNT_W(CNT_W)) u_regs (
    .req_i, .we_i, .addr_i, .wdata_i, .flash_dq_i,
    .lp_i(lp_acc_w), .cp_i(cp_acc_w), .cnt_i(cnt_w),
    .rdata_o, .byte_o(byte_w), .clear_o(clear_w), .step_o(step_w),
    .flash_we_o, .flash_re_o
  );

  ecc_byte_parity #(.DATA_W(DATA_W)) u_par (
    .byte_i(byte_w), .cp_o(cp_byte_w), .rp_o(rp_w)
  );

  ecc_step_acc #(.CNT_W(CNT_W), .CP_W(CP_W)) u_acc (
    .clk_i, .rst_ni, .clear_i(clear_w), .step_i(step_w),
    .rp_i(rp_w), .cp_i(cp_byte_w),
    .lp_o(lp_acc_w), .cp_o(cp_acc_w), .cnt_o(cnt_w)
  );

  assign flash_dq_o = wdata_i;

  p_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == OFS_CLR) |=>
      (lp_acc_w == '0 && cp_acc_w == '0 && cnt_w == '0));

  p_cp_upper_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i == OFS_CP) |-> (rdata_o[7:6] == 2'b00));

  p_strobe_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(flash_we_o && flash_re_o));
endmodule

// File: tb/tb_nand_ecc_accum.sv
module tb_nand_ecc_accum;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A_LPL = 8'h00, A_LPH = 8'h04, A_CP = 8'h08,
                         A_CNT = 8'h0C, A_CLR = 8'h10, A_DAT = 8'h14;

  logic clk = 0, rst_ni = 0;
  logic req = 0, we = 0;
  logic [7:0] addr = '0, wdata = '0, fdq_in = '0;
  logic [7:0] rdata, fdq_out;
  logic fwe, fre;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  nand_ecc_accum dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .flash_dq_i(fdq_in),
    .flash_dq_o(fdq_out), .flash_we_o(fwe), .flash_re_o(fre)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // {we, addr, wdata, expected, check}
  localparam int NV = 16;
  localparam logic [25:0] VEC [NV] = '{
    {1'b1, A_CLR, 8'h5A, 8'h00, 1'b0},
    {1'b1, A_DAT, 8'h01, 8'h00, 1'b0},
    {1'b0, A_LPL, 8'h00, 8'h55, 1'b1},
    {1'b0, A_LPH, 8'h00, 8'h55, 1'b1},
    {1'b0, A_CP,  8'h00, 8'h15, 1'b1},
    {1'b0, A_CNT, 8'h00, 8'h01, 1'b1},
    {1'b1, A_DAT, 8'h03, 8'h00, 1'b0},
    {1'b0, A_CP,  8'h00, 8'h16, 1'b1},
    {1'b1, A_DAT, 8'h80, 8'h00, 1'b0},
    {1'b0, A_LPL, 8'h00, 8'h0C, 1'b1},
    {1'b0, A_LPH, 8'h00, 8'h00, 1'b1},
    {1'b0, A_CP,  8'h00, 8'h3C, 1'b1},
    {1'b1, A_LPL, 8'hAA, 8'h00, 1'b0},
    {1'b0, A_LPL, 8'h00, 8'h0C, 1'b1},
    {1'b0, A_CLR, 8'h00, 8'h00, 1'b1},
    {1'b0, 8'h18, 8'h00, 8'h00, 1'b1}
  };

  task automatic check(string req_tag, logic [15:0] act, logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req_tag, act, exp);
    end
  endtask

  // called at a negedge, returns at the next negedge
  task automatic bus(input logic w, input logic [7:0] a, input logic [7:0] d,
                     output logic [7:0] rd);
    req = 1; we = w; addr = a; wdata = d;
    #1 rd = rdata;
    @(negedge clk);
    req = 0; we = 0;
  endtask

  task automatic rd_regs(output logic [15:0] lp, output logic [5:0] cp,
                         output logic [7:0] cnt);
    logic [7:0] t;
    bus(0, A_LPL, 0, t); lp[7:0]  = t;
    bus(0, A_LPH, 0, t); lp[15:8] = t;
    bus(0, A_CP,  0, t); cp = t[5:0];
    bus(0, A_CNT, 0, t); cnt = t;
  endtask

  logic [7:0] blk [256];

  task automatic model(input int n, output logic [15:0] lp, output logic [5:0] cp);
    lp = '0; cp = '0;
    for (int i = 0; i < n; i++) begin
      logic rp;
      rp = 0;
      for (int b = 0; b < 8; b++) rp ^= blk[i][b];
      for (int b = 0; b < 8; b++)
        for (int j = 0; j < 3; j++)
          if (blk[i][b]) cp[2*j + ((b >> j) & 1)] ^= 1'b1;
      if (rp)
        for (int k = 0; k < 8; k++) lp[2*k + ((i >> k) & 1)] ^= 1'b1;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    logic [15:0] lp, elp;
    logic [5:0] cp, ecp;
    logic [7:0] cnt;

    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);

    // R1 reset state
    rd_regs(lp, cp, cnt);
    check("R1 lp", lp, 16'h0);
    check("R1 cp", {10'h0, cp}, 16'h0);
    check("R1 cnt", {8'h0, cnt}, 16'h0);

    // table walk: R4 R5 R7 R8 R6
    for (int v = 0; v < NV; v++) begin
      bus(VEC[v][25], VEC[v][24:17], VEC[v][16:9], r);
      if (VEC[v][0]) check("R4/R5/R7/R8 vec", {8'h0, r}, {8'h0, VEC[v][8:1]});
    end

    // R6 clear zeroes everything (written data irrelevant)
    bus(1, A_CLR, 8'hFF, r);
    rd_regs(lp, cp, cnt);
    check("R6 lp", lp, 16'h0);
    check("R6 cp", {10'h0, cp}, 16'h0);
    check("R6 cnt", {8'h0, cnt}, 16'h0);

    // R8 writes to read-only counter ignored
    bus(1, A_CNT, 8'h77, r);
    bus(0, A_CNT, 0, r);
    check("R8 cnt ro", {8'h0, r}, 16'h0);

    // R9 write path strobes
    req = 1; we = 1; addr = A_DAT; wdata = 8'hC3;
    #1;
    check("R9 dq_o", {8'h0, fdq_out}, 16'h00C3);
    check("R9 we strobe", {14'h0, fwe, fre}, 16'h2);
    @(negedge clk); req = 0; we = 0;
    bus(1, A_CLR, 0, r);

    // full random step by writes: R3 R4 R5
    for (int i = 0; i < 256; i++) blk[i] = 8'($urandom);
    for (int i = 0; i < 256; i++) bus(1, A_DAT, blk[i], r);
    model(256, elp, ecp);
    rd_regs(lp, cp, cnt);
    check("R5 full lp", lp, elp);
    check("R4 full cp", {10'h0, cp}, {10'h0, ecp});
    check("R3 wrap cnt", {8'h0, cnt}, 16'h0);

    // partial step via flash reads: R2 R9
    bus(1, A_CLR, 0, r);
    for (int i = 0; i < 37; i++) begin
      blk[i] = 8'($urandom);
      fdq_in = blk[i];
      req = 1; we = 0; addr = A_DAT;
      #1;
      if (i == 5) begin
        check("R9 rdata", {8'h0, rdata}, {8'h0, blk[i]});
        check("R9 re strobe", {14'h0, fwe, fre}, 16'h1);
      end
      @(negedge clk); req = 0;
    end
    model(37, elp, ecp);
    rd_regs(lp, cp, cnt);
    check("R2 partial cnt", {8'h0, cnt}, 16'd37);
    check("R5 partial lp", lp, elp);
    check("R4 partial cp", {10'h0, cp}, {10'h0, ecp});

    // clear mid-step: R6
    for (int i = 0; i < 100; i++) bus(1, A_DAT, 8'($urandom), r);
    bus(1, A_CLR, 8'h3C, r);
    for (int i = 0; i < 50; i++) begin
      blk[i] = 8'($urandom);
      bus(1, A_DAT, blk[i], r);
    end
    model(50, elp, ecp);
    rd_regs(lp, cp, cnt);
    check("R6 mid lp", lp, elp);
    check("R6 mid cp", {10'h0, cp}, {10'h0, ecp});
    check("R6 mid cnt", {8'h0, cnt}, 16'd50);

    // R2 register reads do not count
    check("R2 reads no count", {8'h0, cnt}, 16'd50);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule